// File: doc/BRIEF.md
# Folded Walsh-Hadamard Transform Core

This block computes the Walsh-Hadamard transform of a block of N = 2^LOG_N signed fixed-point samples. A whole block is presented at once on a parallel load port. The core transforms it and returns all N results at once on a parallel result port, with a one-cycle valid pulse. While a block is in flight the core raises `busy` and ignores further loads.

Internally every one of the LOG_N butterfly stages has the same wiring. The stage first gathers even-indexed words, then odd-indexed words. It then passes each adjacent pair of the gathered vector through a sum/difference butterfly. Because all stages are alike, only LOG_N/HF physical stages are built, each followed by a register. The data is recirculated through them HF times, where the compile-time folding factor HF divides LOG_N. Each physical stage takes one clock. A block therefore costs LOG_N stage cycles, plus one capture cycle and one cycle to register the result.

The controller has three states. IDLE waits for a load. LOOP runs the stage cycles. FLUSH registers the result and returns to IDLE. The transitions are as follows. IDLE goes to LOOP when `load_valid` is sampled high. LOOP stays in LOOP until its step counter reaches LOG_N-1, and then goes to FLUSH. FLUSH always goes to IDLE.

Top module: `wht_fold_core`

## Requirements
- R1: For input words x[m], with word m at bits [m*IN_W +: IN_W], result word k equals the sum over m of x[m]·(-1)^popcount(k AND m), in natural order.
- R2: Each result word is IN_W+LOG_N bits wide and is two's complement. Word k sits at bits [k*(IN_W+LOG_N) +: IN_W+LOG_N]. The value is exact, with no saturation or truncation, and this includes all-minimum and all-maximum inputs.
- R3: When a load is accepted on clock edge E, `res_valid` is high only in the cycle that follows edge E+LOG_N+1. It is a single-cycle pulse.
- R4: `busy` is high from the edge that accepts a load until the edge that raises `res_valid`, which is LOG_N+1 cycles in all. `busy` is low otherwise.
- R5: A `load_valid` sampled while `busy` is high is ignored. The pending result still belongs to the first block, and no extra result pulse appears.
- R6: The synchronous reset `rst` clears `busy`, `res_valid` and `res_data` to zero on the next clock edge, even in the middle of a transform.
- R7: `res_data` keeps its value in every cycle in which `res_valid` is low.
- R8: A load presented in the same cycle as the `res_valid` pulse is accepted. Its result follows LOG_N+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | Load request for `load_data` |
| load_data | input | N*IN_W | N signed input words, word m at bits [m*IN_W +: IN_W] |
| busy | output | 1 | High while a block is in flight |
| res_valid | output | 1 | One-cycle pulse when `res_data` is new |
| res_data | output | N*(IN_W+LOG_N) | N signed result words |

## Verification
A stale or misrouted internal word, such as a wrong gather index, a swapped butterfly sign or a feedback taken from the wrong pass, corrupts specific result words. This shows up at the very next `res_valid` pulse, LOG_N+1 cycles after the load. Impulses at every position, extreme-value blocks and a long pseudo-random sweep expose every word and sign. A miscounted loop or a faulty state transition moves or repeats the pulse, or stretches `busy`. The bench checks the ports on every cycle of each transform, so such a fault is caught within that cycle.

// File: rtl/wht_fold_pkg.sv
package wht_fold_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOP  = 2'd1,
        ST_FLUSH = 2'd2
    } wht_state_e;

endpackage

// File: rtl/wht_butterfly.sv
module wht_butterfly #(
    parameter int W = 11
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] sum,
    output logic signed [W-1:0] dif
);

    assign sum = a + b;
    assign dif = a - b;

endmodule

// File: rtl/wht_pease_stage.sv
module wht_pease_stage #(
    parameter int N_PTS = 8,
    parameter int W     = 11
) (
    input  logic [N_PTS*W-1:0] x,
    output logic [N_PTS*W-1:0] y
);

    localparam int HALF = N_PTS / 2;

    logic [N_PTS*W-1:0] gathered;

    // gather: slot q reads word 2*(q mod HALF) + q/HALF
    for (genvar q = 0; q < N_PTS; q++) begin : g_gather
        localparam int SRC = 2 * (q % HALF) + (q / HALF);
        assign gathered[q*W +: W] = x[SRC*W +: W];
    end

    for (genvar k = 0; k < HALF; k++) begin : g_bfly
        wht_butterfly #(.W(W)) u_bf (
            .a   (gathered[(2*k)*W +: W]),
            .b   (gathered[(2*k+1)*W +: W]),
            .sum (y[(2*k)*W +: W]),
            .dif (y[(2*k+1)*W +: W])
        );
    end

endmodule

// File: rtl/wht_fold_core.sv
module wht_fold_core
    import wht_fold_pkg::*;
#(
    parameter int LOG_N = 3,
    parameter int IN_W  = 8,
    parameter int HF    = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                load_valid,
    input  logic [(1<<LOG_N)*IN_W-1:0]          load_data,
    output logic                                busy,
    output logic                                res_valid,
    output logic [(1<<LOG_N)*(IN_W+LOG_N)-1:0]  res_data
);

    localparam int N_PTS   = 1 << LOG_N;
    localparam int OUT_W   = IN_W + LOG_N;
    localparam int RES_VEC = N_PTS * OUT_W;
    localparam int PHYS    = LOG_N / HF;
    localparam int STEP_W  = $clog2(LOG_N + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(LOG_N - 1);

    if ((LOG_N % HF) != 0 || HF < 1) begin : g_bad_fold
        $error("HF must divide LOG_N");
    end

    wht_state_e state_q, state_d;

    logic [STEP_W-1:0]  step_q;
    logic [RES_VEC-1:0] hold_q;
    logic [RES_VEC-1:0] res_q;
    logic               res_vld_q;
    logic [RES_VEC-1:0] load_ext;
    logic [RES_VEC-1:0] stage_in  [PHYS];
    logic [RES_VEC-1:0] stage_out [PHYS];
    logic [RES_VEC-1:0] pipe_q    [PHYS];

    // sign-extend every input word to the full result width
    for (genvar e = 0; e < N_PTS; e++) begin : g_ext
        assign load_ext[e*OUT_W +: OUT_W] = OUT_W'($signed(load_data[e*IN_W +: IN_W]));
    end

    // physical stage chain; stage 0 is fed by the captured block or the loop-back
    for (genvar s = 0; s < PHYS; s++) begin : g_stage
        if (s == 0) begin : g_head
            assign stage_in[s] = (step_q == '0) ? hold_q : pipe_q[PHYS-1];
        end else begin : g_body
            assign stage_in[s] = pipe_q[s-1];
        end
        wht_pease_stage #(.N_PTS(N_PTS), .W(OUT_W)) u_stage (
            .x (stage_in[s]),
            .y (stage_out[s])
        );
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load_valid)          state_d = ST_LOOP;
            ST_LOOP:  if (step_q == LAST_STEP) state_d = ST_FLUSH;
            ST_FLUSH:                          state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q    <= '0;
            hold_q    <= '0;
            res_q     <= '0;
            res_vld_q <= 1'b0;
            for (int s = 0; s < PHYS; s++) pipe_q[s] <= '0;
        end else begin
            res_vld_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (load_valid) begin
                        hold_q <= load_ext;
                        step_q <= '0;
                    end
                end
                ST_LOOP: begin
                    step_q <= step_q + 1'b1;
                    for (int s = 0; s < PHYS; s++) pipe_q[s] <= stage_out[s];
                end
                ST_FLUSH: begin
                    res_q     <= pipe_q[PHYS-1];
                    res_vld_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        res_valid = res_vld_q;
        res_data  = res_q;
    end

endmodule

// File: rtl/wht_fold_checker.sv
module wht_fold_checker #(
    parameter int LOG_N   = 3,
    parameter int RES_VEC = 88
) (
    input logic               clk,
    input logic               rst,
    input logic               load_valid,
    input logic               busy,
    input logic               res_valid,
    input logic [RES_VEC-1:0] res_data
);

    int span_q;

    always_ff @(posedge clk) begin
        if (rst)       span_q <= 0;
        else if (busy) span_q <= span_q + 1;
        else           span_q <= 0;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);                                          // R3

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> (span_q == LOG_N + 1));            // R4

    AST_BUSY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!busy && load_valid) |=> busy);                                    // R4

    AST_RESULT_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (!busy && $past(busy)));                              // R3

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res_data));                                  // R7

endmodule

bind wht_fold_core wht_fold_checker #(
    .LOG_N   (LOG_N),
    .RES_VEC (RES_VEC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_valid (load_valid),
    .busy       (busy),
    .res_valid  (res_valid),
    .res_data   (res_data)
);

// File: tb/sim_wht_fold_core.sv
module sim_wht_fold_core;

    localparam int  LOG_N   = 3;
    localparam int  IN_W    = 8;
    localparam int  HF      = 3;
    localparam int  N_PTS   = 1 << LOG_N;
    localparam int  OUT_W   = IN_W + LOG_N;
    localparam int  IN_VEC  = N_PTS * IN_W;
    localparam int  RES_VEC = N_PTS * OUT_W;
    localparam time CLK_PERIOD = 10ns;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               load_valid = 1'b0;
    logic [IN_VEC-1:0]  load_data = '0;
    logic               busy;
    logic               res_valid;
    logic [RES_VEC-1:0] res_data;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2357;

    always #(CLK_PERIOD/2) clk = ~clk;

    wht_fold_core #(.LOG_N(LOG_N), .IN_W(IN_W), .HF(HF)) u0 (
        .clk        (clk),
        .rst        (rst),
        .load_valid (load_valid),
        .load_data  (load_data),
        .busy       (busy),
        .res_valid  (res_valid),
        .res_data   (res_data)
    );

    function automatic logic [RES_VEC-1:0] ref_wht(input logic [IN_VEC-1:0] v);
        logic [RES_VEC-1:0] r;
        r = '0;
        for (int k = 0; k < N_PTS; k++) begin
            int acc;
            acc = 0;
            for (int m = 0; m < N_PTS; m++) begin
                int xm;
                xm = int'($signed(v[m*IN_W +: IN_W]));
                if ($countones(k & m) % 2 == 1) acc -= xm;
                else                            acc += xm;
            end
            r[k*OUT_W +: OUT_W] = acc[OUT_W-1:0];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [RES_VEC-1:0] act, input logic [RES_VEC-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [IN_VEC-1:0] rnd_vec();
        logic [IN_VEC-1:0] v;
        for (int b = 0; b < N_PTS; b++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            v[b*IN_W +: IN_W] = lfsr[IN_W-1:0] ^ lfsr[IN_W+7:8];
        end
        return v;
    endfunction

    // called at a negedge: present the block for the next edge
    task automatic issue(input logic [IN_VEC-1:0] v);
        load_valid = 1'b1;
        load_data  = v;
    endtask

    // walk one transform from the accepting edge to the result pulse
    task automatic finish(input logic [IN_VEC-1:0] v, input bit poke, input string tag);
        logic [RES_VEC-1:0] exp;
        exp = ref_wht(v);
        @(negedge clk);
        load_valid = 1'b0;
        chk(busy === 1'b1, "R4", {tag, " busy after accept"}, RES_VEC'(busy), RES_VEC'(1));
        for (int k = 1; k <= LOG_N; k++) begin
            if (poke && k == 1) begin
                load_valid = 1'b1;          // R5: load while busy
                load_data  = ~v;
            end
            @(negedge clk);
            load_valid = 1'b0;
            chk(res_valid === 1'b0, "R3", {tag, " early pulse"}, RES_VEC'(res_valid), '0);
            chk(busy === 1'b1, "R4", {tag, " busy held"}, RES_VEC'(busy), RES_VEC'(1));
        end
        @(negedge clk);
        chk(res_valid === 1'b1, "R3", {tag, " pulse at LOG_N+1"}, RES_VEC'(res_valid), RES_VEC'(1));
        chk(busy === 1'b0, "R4", {tag, " busy drop"}, RES_VEC'(busy), '0);
        chk(res_data === exp, poke ? "R5" : "R1", {tag, " result"}, res_data, exp);
    endtask

    task automatic after_pulse(input string tag);
        logic [RES_VEC-1:0] held;
        held = res_data;
        @(negedge clk);
        chk(res_valid === 1'b0, "R3", {tag, " single pulse"}, RES_VEC'(res_valid), '0);
        chk(res_data === held, "R7", {tag, " result hold"}, res_data, held);
    endtask

    task automatic one(input logic [IN_VEC-1:0] v, input string tag);
        @(negedge clk);
        issue(v);
        finish(v, 1'b0, tag);
        after_pulse(tag);
    endtask

    initial begin
        logic [IN_VEC-1:0] v;
        logic [IN_VEC-1:0] w;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && res_valid === 1'b0, "R6", "reset flags",
            RES_VEC'({busy, res_valid}), '0);
        chk(res_data === '0, "R6", "reset data", res_data, '0);
        rst = 1'b0;

        // R1: zero block and impulses at every position, both signs
        one('0, "R1 zero");
        for (int m = 0; m < N_PTS; m++) begin
            v = '0;
            v[m*IN_W +: IN_W] = IN_W'(m + 1);
            one(v, "R1 impulse+");
            v[m*IN_W +: IN_W] = IN_W'(-(m + 3));
            one(v, "R1 impulse-");
        end

        // R2: extremes, full word growth without saturation
        for (int m = 0; m < N_PTS; m++) v[m*IN_W +: IN_W] = {1'b1, {(IN_W-1){1'b0}}};
        one(v, "R2 all-min");
        for (int m = 0; m < N_PTS; m++) v[m*IN_W +: IN_W] = {1'b0, {(IN_W-1){1'b1}}};
        one(v, "R2 all-max");
        for (int m = 0; m < N_PTS; m++)
            v[m*IN_W +: IN_W] = (m % 2 == 0) ? {1'b0, {(IN_W-1){1'b1}}} : {1'b1, {(IN_W-1){1'b0}}};
        one(v, "R2 alternating");

        // R1: pseudo-random sweep
        for (int t = 0; t < 300; t++) one(rnd_vec(), "R1 random");

        // R5: load while busy is ignored, no extra pulse
        for (int t = 0; t < 4; t++) begin
            v = rnd_vec();
            @(negedge clk);
            issue(v);
            finish(v, 1'b1, "R5 busy-load");
            after_pulse("R5 busy-load");
            repeat (LOG_N + 2) begin
                @(negedge clk);
                chk(res_valid === 1'b0 && busy === 1'b0, "R5", "no extra run",
                    RES_VEC'({busy, res_valid}), '0);
            end
        end

        // R8: back-to-back load in the pulse cycle
        v = rnd_vec();
        w = rnd_vec();
        @(negedge clk);
        issue(v);
        finish(v, 1'b0, "R8 first");
        issue(w);
        finish(w, 1'b0, "R8 second");
        after_pulse("R8 second");

        // R6: reset in the middle of a transform
        v = rnd_vec();
        @(negedge clk);
        issue(v);
        @(negedge clk);
        load_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && res_valid === 1'b0, "R6", "mid-run reset flags",
            RES_VEC'({busy, res_valid}), '0);
        chk(res_data === '0, "R6", "mid-run reset data", res_data, '0);
        @(negedge clk);
        rst = 1'b0;
        one(rnd_vec(), "R6 after reset");

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule